// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block holds the digital half of a successive-approximation converter. A start strobe begins a conversion. The block then drives a trial code to an external DAC and reads back one comparator bit: high means the trial voltage is above the input. It runs a binary search from the most significant bit down to bit zero. Each trial code is held long enough for the DAC and comparator to settle before the comparator bit is taken. At the end the block latches the code it has found and raises a single-cycle completion pulse.

Two choices are captured at start: a 10-bit or 8-bit resolution and an optional sample phase that drives the hold switch. The total length of a conversion is fixed for each combination at 33, 28, 59 or 49 conversion ticks. A selectable divider derives the conversion tick from the input clock. The analog parts are not part of this block.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is held and until the first start, busy, done, sample_hold, dac_code and result are all zero.
- R2: A start seen while idle sets busy at the next clock edge and clears dac_code. A start seen while busy has no effect on the running conversion. Without start, an idle block keeps dac_code unchanged.
- R3: The search begins at the top bit. Each step sets the next lower bit of the trial code to 1, and clears it again if cmp_hi is 1 when that bit is decided. With an ideal comparator (cmp_hi = trial code > input code), result is the input code, saturated at the full-scale code.
- R4: A conversion lasts a fixed number of conversion ticks: 33 at 10 bits and 28 at 8 bits with the sample phase, 59 at 10 bits and 49 at 8 bits without it.
- R5: div_sel sets the conversion tick to one every 1, 2, 3, 4, 6 or 12 clocks for codes 0 to 5. Codes 6 and 7 also give 12. busy stays high for exactly (tick count × divide ratio) clocks.
- R6: When sh_en is 1, sample_hold is high for the first 13 ticks (10-bit) or 12 ticks (8-bit) of a conversion. When sh_en is 0, sample_hold stays low.
- R7: When mode_8b is 1 the search covers bits 7 to 0 only. result and dac_code then have bits 9 and 8 at zero.
- R8: done is high for one clock, in the first cycle with busy low after a conversion. result takes its new value in that same cycle and keeps it until the next done.
- R9: mode_8b, sh_en and div_sel are captured when a start is accepted. Changing them during a conversion alters neither its timing nor its result.
- R10: Each bit's trial code stays on dac_code for a settling slot of 2 ticks with the sample phase or 5 ticks without it. cmp_hi is used only on the last tick of the slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start-of-conversion strobe |
| mode_8b | input | 1 | 1 selects 8-bit resolution, 0 selects 10-bit |
| sh_en | input | 1 | 1 enables the sample phase |
| div_sel | input | 3 | Conversion tick divider select |
| cmp_hi | input | 1 | Comparator: 1 when trial voltage exceeds the input |
| dac_code | output | 10 | Trial code to the DAC |
| sample_hold | output | 1 | Hold-switch control, high while sampling |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Latched conversion code |

## Verification
busy is due one clock after the edge that samples start. It then lasts exactly the tick total times the divide ratio. The hold switch and each bit's settling slot last their tick counts times that same ratio. done and the new result appear together in the first cycle after busy falls. The bench drives all inputs on falling edges and counts falling edges while busy is high. It compares each count with the product computed from the requirement's numbers, and it reads result and done at the falling edge where busy is first seen low. A second falling-edge sample then confirms that done has dropped and result has held.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int RATIO_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_BITS
  } sar_state_e;

  // divide ratio of the conversion tick; unused codes fall back to the slowest
  function automatic logic [RATIO_W-1:0] div_ratio(input logic [2:0] sel);
    logic [RATIO_W-1:0] r;
    case (sel)
      3'd0:    r = 4'd1;
      3'd1:    r = 4'd2;
      3'd2:    r = 4'd3;
      3'd3:    r = 4'd4;
      3'd4:    r = 4'd6;
      default: r = 4'd12;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sar_clk_en.sv
module sar_clk_en
  import sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       ce
);

  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [RATIO_W-1:0] cnt_q, cnt_d;

  assign ce = (cnt_q == ratio_q - 1'b1);

  always_comb begin
    ratio_d = ratio_q;
    cnt_d   = ce ? '0 : cnt_q + 1'b1;
    if (restart) begin
      ratio_d = div_ratio(sel);
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= 4'd1;
      cnt_q   <= '0;
    end else begin
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sar_timer.sv
module sar_timer
  import sar_pkg::*;
#(
  parameter int RES_HI  = 10,
  parameter int RES_LO  = 8,
  parameter int T_SH_HI = 33,
  parameter int T_SH_LO = 28,
  parameter int T_NS_HI = 59,
  parameter int T_NS_LO = 49,
  parameter int L_SH    = 2,
  parameter int L_NS    = 5,
  localparam int IW     = $clog2(RES_HI)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_8b,
  input  logic          sh_en,
  input  logic          ce,
  output logic          accept,
  output logic          busy,
  output logic          sample,
  output logic          decide,
  output logic          set_en,
  output logic [IW-1:0] set_idx,
  output logic [IW-1:0] cur_idx,
  output logic          finish,
  output logic          cfg_mode8
);

  // setup phase absorbs whatever the bit slots leave of each total
  localparam int SET_SH_HI = T_SH_HI - RES_HI * L_SH;
  localparam int SET_SH_LO = T_SH_LO - RES_LO * L_SH;
  localparam int SET_NS_HI = T_NS_HI - RES_HI * L_NS;
  localparam int SET_NS_LO = T_NS_LO - RES_LO * L_NS;
  localparam int CW        = $clog2(T_NS_HI + 1);

  localparam logic [CW-1:0] END_SH_HI = CW'(SET_SH_HI - 1);
  localparam logic [CW-1:0] END_SH_LO = CW'(SET_SH_LO - 1);
  localparam logic [CW-1:0] END_NS_HI = CW'(SET_NS_HI - 1);
  localparam logic [CW-1:0] END_NS_LO = CW'(SET_NS_LO - 1);
  localparam logic [CW-1:0] END_L_SH  = CW'(L_SH - 1);
  localparam logic [CW-1:0] END_L_NS  = CW'(L_NS - 1);
  localparam logic [IW-1:0] MSB_HI    = IW'(RES_HI - 1);
  localparam logic [IW-1:0] MSB_LO    = IW'(RES_LO - 1);

  sar_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          m8_q, m8_d;
  logic          sh_q, sh_d;
  logic [CW-1:0] setup_end;
  logic [CW-1:0] slot_end;

  always_comb begin
    setup_end = sh_q ? (m8_q ? END_SH_LO : END_SH_HI)
                     : (m8_q ? END_NS_LO : END_NS_HI);
    slot_end  = sh_q ? END_L_SH : END_L_NS;
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    m8_d    = m8_q;
    sh_d    = sh_q;
    accept  = 1'b0;
    decide  = 1'b0;
    set_en  = 1'b0;
    set_idx = idx_q;
    finish  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          st_d   = ST_SETUP;
          cnt_d  = '0;
          m8_d   = mode_8b;
          sh_d   = sh_en;
        end
      end
      ST_SETUP: begin
        if (ce) begin
          if (cnt_q == setup_end) begin
            st_d    = ST_BITS;
            cnt_d   = '0;
            idx_d   = m8_q ? MSB_LO : MSB_HI;
            set_en  = 1'b1;
            set_idx = m8_q ? MSB_LO : MSB_HI;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_BITS: begin
        if (ce) begin
          if (cnt_q == slot_end) begin
            decide = 1'b1;
            cnt_d  = '0;
            if (idx_q == '0) begin
              finish = 1'b1;
              st_d   = ST_IDLE;
            end else begin
              idx_d   = idx_q - 1'b1;
              set_en  = 1'b1;
              set_idx = idx_q - 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      m8_q  <= 1'b0;
      sh_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      m8_q  <= m8_d;
      sh_q  <= sh_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign sample    = (st_q == ST_SETUP) && sh_q;
  assign cur_idx   = idx_q;
  assign cfg_mode8 = m8_q;

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int W   = 10,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          decide,
  input  logic          cmp_hi,
  input  logic [IW-1:0] cur_idx,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          finish,
  output logic [W-1:0]  trial,
  output logic [W-1:0]  result,
  output logic          done
);

  logic [W-1:0] trial_q, trial_d;
  logic [W-1:0] res_q, res_d;
  logic         done_q;

  always_comb begin
    trial_d = trial_q;
    if (clear) begin
      trial_d = '0;
    end else begin
      if (decide && cmp_hi) trial_d[cur_idx] = 1'b0;
      if (set_en)           trial_d[set_idx] = 1'b1;
    end
    res_d = finish ? trial_d : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      trial_q <= trial_d;
      res_q   <= res_d;
      done_q  <= finish;
    end
  end

  assign trial  = trial_q;
  assign result = res_q;
  assign done   = done_q;

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int RES_HI  = 10,
  parameter int RES_LO  = 8,
  parameter int T_SH_HI = 33,
  parameter int T_SH_LO = 28,
  parameter int T_NS_HI = 59,
  parameter int T_NS_LO = 49,
  parameter int L_SH    = 2,
  parameter int L_NS    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_8b,
  input  logic              sh_en,
  input  logic [2:0]        div_sel,
  input  logic              cmp_hi,
  output logic [RES_HI-1:0] dac_code,
  output logic              sample_hold,
  output logic              busy,
  output logic              done,
  output logic [RES_HI-1:0] result
);

  localparam int IW = $clog2(RES_HI);

  logic [1:0]    rst_sync_q;
  logic          rst_n_int;
  logic          ce;
  logic          accept;
  logic          decide;
  logic          set_en;
  logic [IW-1:0] set_idx;
  logic [IW-1:0] cur_idx;
  logic          finish;
  logic          cfg_mode8;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sar_clk_en u_div (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .restart (accept),
    .sel     (div_sel),
    .ce      (ce)
  );

  sar_timer #(
    .RES_HI (RES_HI), .RES_LO (RES_LO),
    .T_SH_HI(T_SH_HI), .T_SH_LO(T_SH_LO),
    .T_NS_HI(T_NS_HI), .T_NS_LO(T_NS_LO),
    .L_SH   (L_SH),    .L_NS   (L_NS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .mode_8b   (mode_8b),
    .sh_en     (sh_en),
    .ce        (ce),
    .accept    (accept),
    .busy      (busy),
    .sample    (sample_hold),
    .decide    (decide),
    .set_en    (set_en),
    .set_idx   (set_idx),
    .cur_idx   (cur_idx),
    .finish    (finish),
    .cfg_mode8 (cfg_mode8)
  );

  sar_approx #(.W(RES_HI)) u_approx (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clear   (accept),
    .decide  (decide),
    .cmp_hi  (cmp_hi),
    .cur_idx (cur_idx),
    .set_en  (set_en),
    .set_idx (set_idx),
    .finish  (finish),
    .trial   (dac_code),
    .result  (result),
    .done    (done)
  );

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int RES_HI = 10,
  parameter int RES_LO = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              sample_hold,
  input logic [RES_HI-1:0] dac_code,
  input logic [RES_HI-1:0] result,
  input logic              cfg_mode8
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R8

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));                             // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));                                   // R8

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);                                   // R2

  AST_IDLE_DAC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(dac_code));                     // R2

  AST_HOLD_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> busy);                                        // R6

  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_mode8) |-> (result[RES_HI-1:RES_LO] == '0));     // R7

endmodule

bind sar_ctrl sar_ctrl_chk #(.RES_HI(RES_HI), .RES_LO(RES_LO)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .sample_hold (sample_hold),
  .dac_code    (dac_code),
  .result      (result),
  .cfg_mode8   (cfg_mode8)
);

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       mode_8b;
  logic       sh_en;
  logic [2:0] div_sel;
  logic       cmp_hi;
  logic [9:0] dac_code;
  logic       sample_hold;
  logic       busy;
  logic       done;
  logic [9:0] result;
  logic [9:0] vin;

  int n_checks;
  int n_fail;

  // ideal comparator
  assign cmp_hi = (dac_code > vin);

  sar_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode_8b     (mode_8b),
    .sh_en       (sh_en),
    .div_sel     (div_sel),
    .cmp_hi      (cmp_hi),
    .dac_code    (dac_code),
    .sample_hold (sample_hold),
    .busy        (busy),
    .done        (done),
    .result      (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [2:0] sel);
    case (sel)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 6;
      default: return 12;
    endcase
  endfunction

  task automatic run_conv(input bit m8, input bit sh, input logic [2:0] sel,
                          input int v, input bit disturb, input string req);
    int ratio, total, hold_exp, slot, msbv, full, expres;
    int nbusy, nhold, nmsb, ndone, guard;
    logic [9:0] res_seen;
    ratio    = exp_ratio(sel);
    total    = m8 ? (sh ? 28 : 49) : (sh ? 33 : 59);
    hold_exp = sh ? (m8 ? 12 : 13) * ratio : 0;
    slot     = sh ? 2 : 5;
    msbv     = m8 ? 128 : 512;
    full     = m8 ? 255 : 1023;
    expres   = (v > full) ? full : v;
    @(negedge clk);
    vin = 10'(v); mode_8b = m8; sh_en = sh; div_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, {req, " R2 busy after start"}, int'(busy), 1);
    chk(dac_code === 10'd0 || sel == 3'd0 || total == 0,
        {req, " R2 dac cleared"}, int'(dac_code), 0);
    nbusy = 0; nhold = 0; nmsb = 0; ndone = 0; guard = 0;
    while (busy === 1'b1 && guard < 2000) begin
      nbusy++;
      if (sample_hold) nhold++;
      if (dac_code == 10'(msbv)) nmsb++;
      if (done) ndone++;
      if (disturb && nbusy == 3) begin
        mode_8b = ~m8; sh_en = ~sh; div_sel = sel ^ 3'd1;
      end
      if (disturb && nbusy == 5) start = 1'b1;
      if (disturb && nbusy == 6) start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    chk(nbusy == total * ratio, {req, " R4 R5 busy clocks"}, nbusy, total * ratio);
    chk(ndone == 0, {req, " R8 no done while busy"}, ndone, 0);
    chk(done === 1'b1, {req, " R8 done at busy fall"}, int'(done), 1);
    chk(result == 10'(expres), {req, " R3 result"}, int'(result), expres);
    chk(nhold == hold_exp, {req, " R6 hold clocks"}, nhold, hold_exp);
    if (m8) chk(result[9:8] == 2'b00, {req, " R7 upper bits"}, int'(result[9:8]), 0);
    if (v < msbv)
      chk(nmsb == slot * ratio, {req, " R10 top-bit slot"}, nmsb, slot * ratio);
    res_seen = result;
    @(negedge clk);
    chk(done === 1'b0, {req, " R8 done one cycle"}, int'(done), 0);
    chk(result == res_seen, {req, " R8 result held"}, int'(result), int'(res_seen));
    chk(busy === 1'b0, {req, " R2 stays idle"}, int'(busy), 0);
    mode_8b = m8; sh_en = sh; div_sel = sel;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; mode_8b = 1'b0; sh_en = 1'b1; div_sel = 3'd0; vin = '0;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && sample_hold === 1'b0,
        "R1 control outputs in reset", int'({busy, done, sample_hold}), 0);
    chk(dac_code === 10'd0 && result === 10'd0, "R1 codes in reset",
        int'(dac_code) + int'(result), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && result === 10'd0, "R1 idle after release",
        int'(busy) + int'(result), 0);
  endtask

  task automatic t_sample_wide;
    run_conv(1'b0, 1'b1, 3'd0, 300, 1'b0, "sh10a");
    run_conv(1'b0, 1'b1, 3'd1, 5, 1'b0, "sh10b");
  endtask

  task automatic t_sample_narrow;  // R7
    run_conv(1'b1, 1'b1, 3'd0, 77, 1'b0, "sh8a");
    run_conv(1'b1, 1'b1, 3'd2, 200, 1'b0, "sh8b");
  endtask

  task automatic t_no_sample;
    run_conv(1'b0, 1'b0, 3'd0, 1000, 1'b0, "ns10");
    run_conv(1'b1, 1'b0, 3'd3, 3, 1'b0, "ns8");
  endtask

  task automatic t_dividers;  // R5
    for (int s = 0; s < 8; s++)
      run_conv(1'b0, 1'b1, 3'(s), 100 + s, 1'b0, "div");
  endtask

  task automatic t_edges;  // R3 R7
    run_conv(1'b0, 1'b1, 3'd0, 0, 1'b0, "zero");
    run_conv(1'b0, 1'b0, 3'd0, 1023, 1'b0, "full10");
    run_conv(1'b1, 1'b1, 3'd1, 1023, 1'b0, "clamp8");
    run_conv(1'b0, 1'b1, 3'd0, 512, 1'b0, "mid");
    run_conv(1'b0, 1'b1, 3'd0, 511, 1'b0, "belowmid");
  endtask

  task automatic t_cfg_change;  // R9, also R2 restart ignored
    run_conv(1'b0, 1'b1, 3'd1, 450, 1'b1, "R9 cfgA");
    run_conv(1'b1, 1'b0, 3'd0, 60, 1'b1, "R9 cfgB");
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    t_reset();
    t_sample_wide();
    t_sample_narrow();
    t_no_sample();
    t_dividers();
    t_edges();
    t_cfg_change();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule